// File: doc/BRIEF.md
# I2C EEPROM Target Engine

This block is the bus side of a serial byte-addressed memory. It watches an SCL and SDA pair that is already synchronized to the system clock and sampled several times per bit. It answers as an I2C target, and it pulls SDA low through an open-drain enable. The memory has 2048 bytes and is addressed by 11 bits. The high three address bits ride in the slave byte and the low eight bits follow in the next byte. A single byte written to the engine is committed when the stop arrives. The engine then stays busy for a set number of clocks, and during that time it answers no slave byte. The host can therefore poll with a slave byte until it sees an acknowledge.

The engine keeps a current-address register that lasts from one command to the next. A current-address read returns the byte that follows the last one accessed. A random read is a write that carries only the address, followed by a repeated start and a read slave byte. While the master keeps acknowledging, the read continues through consecutive bytes and wraps from the top of memory to address zero. If a read is cut short by a start or a stop, the engine drops the current address. A read slave byte is then refused until a new word address has been loaded.

Top module: `i2c_eeprom_target`

## Requirements
- R1: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. A start is seen in any state and restarts slave-byte reception, which abandons any command in progress.
- R2: Only a slave byte whose bits 7..4 are 1010 is acknowledged. Any other value gets no ACK. The engine then ignores the bus until the next start.
- R3: Slave-byte bits 3..1 become word address bits 10..8. The next byte received in a write supplies bits 7..0.
- R4: The engine pulls SDA low during the ninth clock after an accepted slave byte. It does the same after each word-address byte and each write-data byte.
- R5: At a stop that ends a write, the last data byte received is stored at the word address while the write-protect input is low. The current address then becomes that address plus one.
- R6: If write protect is high at the stop, the memory is left unchanged and no busy period starts. The bytes are still acknowledged.
- R7: A random read returns the byte stored at the address that was given in its address-only write.
- R8: A current-address read returns the byte at the last accessed address plus one. The address wraps from 7FFh to 000h.
- R9: In a read, a master ACK (SDA low in the ninth clock) makes the engine send the next byte. A master NACK makes it release SDA and wait for a stop.
- R10: A start or stop that arrives during a read byte invalidates the current address. Read slave bytes then get no ACK until a word address is loaded again.
- R11: For WRITE_CYCLES clocks after a committed write, every slave byte goes unacknowledged.
- R12: The SDA pull-down is asserted only while SCL is low, which means output changes follow an SCL fall. Reset releases it at once.
- R13: After reset the current address is invalid, so a current-address read is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA bus level |
| wp_in | input | 1 | Write protect; high blocks memory updates |
| sda_low | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench goes after several cases where a wrong design gives wrong answers.

- **Address wrap.** It writes at 7FFh and 000h and then does a current-address read. A design that carries into a twelfth bit, or that treats the page bits as ignored, returns the wrong byte.
- **Aborted reads.** It cuts reads short with both a start and a stop, then tries a current-address read. A design that keeps the address valid acknowledges a read it should refuse.
- **Busy and write protect.** It polls straight after a write and after a protected write. Skipping the busy period shows up as an early ACK. A wrong write-protect path shows up either as a changed byte or as a needless busy period.
- **Slave byte and reset.** It sends foreign device codes, and it resets while the engine holds an ACK. A bad comparison, or a synchronous release, is visible on SDA.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int ADDR_W = 11,
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wp_in,
  output logic sda_low
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_DEV   = 3'd1;
  localparam logic [2:0] ST_WADR  = 3'd2;
  localparam logic [2:0] ST_WDAT  = 3'd3;
  localparam logic [2:0] ST_RD    = 3'd4;
  localparam logic [2:0] ST_WSTOP = 3'd5;

  logic [7:0]        mem [DEPTH];
  logic              scl_q, sda_q;
  logic [2:0]        state;
  logic [3:0]        bitcnt;
  logic [7:0]        sh, tx, pend_data, rdata;
  logic [HI_W-1:0]   hi_adr;
  logic [ADDR_W-1:0] cur_addr;
  logic              valid, rd_mode, pend, mack, busy, commit;
  logic [CNT_W-1:0]  busy_cnt;

  wire scl_rise = scl_in & ~scl_q;
  wire scl_fall = ~scl_in & scl_q;
  wire start_c  = scl_in & scl_q & sda_q & ~sda_in;
  wire stop_c   = scl_in & scl_q & ~sda_q & sda_in;

  assign busy   = busy_cnt != '0;
  assign rdata  = mem[cur_addr];
  assign commit = stop_c && state == ST_WDAT && pend && !wp_in;

  always_ff @(posedge clk) begin
    if (commit) mem[cur_addr] <= pend_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      state     <= ST_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      tx        <= '0;
      pend_data <= '0;
      hi_adr    <= '0;
      cur_addr  <= '0;
      valid     <= 1'b0;
      rd_mode   <= 1'b0;
      pend      <= 1'b0;
      mack      <= 1'b1;
      busy_cnt  <= '0;
      sda_low   <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (busy) busy_cnt <= busy_cnt - CNT_W'(1);

      if (start_c) begin
        if (state == ST_RD) valid <= 1'b0;
        state   <= ST_DEV;
        bitcnt  <= '0;
        sda_low <= 1'b0;
        pend    <= 1'b0;
      end else if (stop_c) begin
        if (state == ST_RD) valid <= 1'b0;
        if (commit) begin
          cur_addr <= cur_addr + ADDR_W'(1);
          busy_cnt <= CNT_W'(WRITE_CYCLES);
        end
        state   <= ST_IDLE;
        sda_low <= 1'b0;
        pend    <= 1'b0;
      end else if (state inside {ST_DEV, ST_WADR, ST_WDAT}) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) sh <= {sh[6:0], sda_in};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          case (state)
            ST_DEV:
              if (sh[7:4] == DEV_CODE && !busy && (!sh[0] || valid)) begin
                sda_low <= 1'b1;
                rd_mode <= sh[0];
                hi_adr  <= sh[HI_W:1];
              end else begin
                state <= ST_IDLE;
              end
            ST_WADR: begin
              sda_low  <= 1'b1;
              cur_addr <= {hi_adr, sh};
              valid    <= 1'b1;
            end
            default: begin
              sda_low   <= 1'b1;
              pend      <= 1'b1;
              pend_data <= sh;
            end
          endcase
        end else if (scl_fall && bitcnt == 4'd9) begin
          sda_low <= 1'b0;
          bitcnt  <= '0;
          case (state)
            ST_DEV:
              if (rd_mode) begin
                state   <= ST_RD;
                tx      <= rdata;
                sda_low <= ~rdata[7];
              end else begin
                state <= ST_WADR;
              end
            ST_WADR: state <= ST_WDAT;
            default: state <= ST_WDAT;
          endcase
        end
      end else if (state == ST_RD) begin
        if (scl_rise) begin
          if (bitcnt == 4'd8) begin
            mack     <= sda_in;
            cur_addr <= cur_addr + ADDR_W'(1);
          end
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (bitcnt != 4'd0 && bitcnt < 4'd8) begin
            tx      <= {tx[6:0], 1'b0};
            sda_low <= ~tx[6];
          end else if (bitcnt == 4'd8) begin
            sda_low <= 1'b0;
          end else if (bitcnt == 4'd9) begin
            if (!mack) begin
              bitcnt  <= '0;
              tx      <= rdata;
              sda_low <= ~rdata[7];
            end else begin
              state <= ST_WSTOP;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_in,
  input logic       sda_low,
  input logic [2:0] state,
  input logic       busy,
  input logic       valid
);
  localparam logic [2:0] C_IDLE  = 3'd0;
  localparam logic [2:0] C_DEV   = 3'd1;
  localparam logic [2:0] C_RD    = 3'd4;
  localparam logic [2:0] C_WSTOP = 3'd5;

  // R12
  sda_pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !scl_in);

  // R12
  always @(posedge clk) begin
    if (!rst_n) reset_release_chk: assert (!sda_low);
  end

  // R11
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state == C_DEV) |-> !sda_low);

  // R10
  invalid_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> state != C_RD);

  // R9
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_IDLE || state == C_WSTOP) |-> !sda_low);

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && $past(scl_in) && $past(sda_in) && !sda_in) |=> state == C_DEV);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
  .sda_low(sda_low), .state(state), .busy(busy), .valid(valid)
);

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;
  localparam int Q = 4;
  localparam int NV = 13;
  // [20:19] op (0 write, 1 random read, 2 current read), [18:8] addr, [7:0] data
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 11'h123, 8'hA5}, {2'd0, 11'h124, 8'h3C}, {2'd0, 11'h125, 8'h0F},
    {2'd0, 11'h126, 8'hC3}, {2'd0, 11'h7FF, 8'h81}, {2'd0, 11'h000, 8'h7E},
    {2'd0, 11'h400, 8'h55}, {2'd1, 11'h123, 8'hA5}, {2'd2, 11'h000, 8'h3C},
    {2'd2, 11'h000, 8'h0F}, {2'd1, 11'h7FF, 8'h81}, {2'd2, 11'h000, 8'h7E},
    {2'd1, 11'h400, 8'h55}
  };

  logic clk = 1'b0;
  logic rst_n, scl, m_sda, wp;
  wire  sda_low;
  wire  sda_bus = m_sda & ~sda_low;
  int   n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  i2c_eeprom_target #(.WRITE_CYCLES(600)) u_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .wp_in(wp), .sda_low(sda_low)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = !sda_bus;
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b1; tick(Q); b[i] = sda_bus; scl = 1'b0; tick(Q);
    end
    m_sda = m_ack ? 1'b0 : 1'b1; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [10:0] a, input logic [7:0] d, output bit ok);
    bit k1, k2, k3;
    i2c_start();
    send_byte({4'hA, a[10:8], 1'b0}, k1);
    send_byte(a[7:0], k2);
    send_byte(d, k3);
    i2c_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic poll_idle(output int n);
    bit a;
    n = 0;
    do begin
      i2c_start(); send_byte(8'hA0, a); i2c_stop(); n++;
    end while (!a && n < 100);
  endtask

  task automatic rand_read(input logic [10:0] a, output bit ok, output logic [7:0] d);
    bit k1, k2, k3;
    d = '0;
    i2c_start();
    send_byte({4'hA, a[10:8], 1'b0}, k1);
    send_byte(a[7:0], k2);
    i2c_start();
    send_byte(8'hA1, k3);
    if (k3) recv_byte(1'b0, d);
    i2c_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic cur_read(output bit ok, output logic [7:0] d);
    d = '0;
    i2c_start();
    send_byte(8'hA1, ok);
    if (ok) recv_byte(1'b0, d);
    i2c_stop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit ok, a;
    int n;
    logic [7:0] d, d0, d1, d2;
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; wp = 1'b0;
    tick(5);
    check(sda_low == 1'b0, "R12 released in reset", sda_low, 0);
    rst_n = 1'b1;
    tick(5);
    cur_read(ok, d);
    check(!ok, "R13 current read refused after reset", ok, 0);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k][20:19])
        2'd0: begin
          do_write(VEC[k][18:8], VEC[k][7:0], ok);
          check(ok, "R4 acks on write", ok, 1);
          poll_idle(n);
          check(n < 100, "R11 busy ends", n, 1);
        end
        2'd1: begin
          rand_read(VEC[k][18:8], ok, d);
          check(ok, "R7 random read ack", ok, 1);
          check(d == VEC[k][7:0], "R7 R3 R5 random read data", d, VEC[k][7:0]);
        end
        default: begin
          cur_read(ok, d);
          check(ok && d == VEC[k][7:0], "R8 current read data", d, VEC[k][7:0]);
        end
      endcase
    end

    // R9 sequential read, then R8 follow-on
    i2c_start(); send_byte(8'hA2, a); send_byte(8'h23, a);
    i2c_start(); send_byte(8'hA1, a);
    recv_byte(1'b1, d0); recv_byte(1'b1, d1); recv_byte(1'b0, d2);
    check(sda_low == 1'b0, "R9 released after master NACK", sda_low, 0);
    i2c_stop();
    check(d0 == 8'hA5, "R9 seq byte0", d0, 8'hA5);
    check(d1 == 8'h3C, "R9 seq byte1", d1, 8'h3C);
    check(d2 == 8'h0F, "R9 seq byte2", d2, 8'h0F);
    cur_read(ok, d);
    check(ok && d == 8'hC3, "R8 current after sequential", d, 8'hC3);

    // R11 busy window
    do_write(11'h010, 8'h99, ok);
    i2c_start(); send_byte(8'hA0, a); i2c_stop();
    check(!a, "R11 slave byte refused while busy", a, 0);
    poll_idle(n);
    check(n >= 2 && n < 100, "R11 polls needed", n, 2);
    rand_read(11'h010, ok, d);
    check(d == 8'h99, "R5 data after busy", d, 8'h99);

    // R6 write protect
    wp = 1'b1;
    do_write(11'h123, 8'hFF, ok);
    wp = 1'b0;
    check(ok, "R6 acks under protect", ok, 1);
    i2c_start(); send_byte(8'hA0, a); i2c_stop();
    check(a, "R6 no busy after protected write", a, 1);
    rand_read(11'h123, ok, d);
    check(d == 8'hA5, "R6 memory unchanged", d, 8'hA5);

    // R2 foreign device codes
    i2c_start(); send_byte(8'hB0, a);
    check(!a, "R2 code 1011 refused", a, 0);
    send_byte(8'h00, a);
    check(!a, "R2 following byte ignored", a, 0);
    i2c_stop();
    i2c_start(); send_byte(8'h20, a); i2c_stop();
    check(!a, "R2 code 0010 refused", a, 0);
    rand_read(11'h124, ok, d);
    check(ok && d == 8'h3C, "R2 normal access after refusal", d, 8'h3C);

    // R10 R1 abort by start
    i2c_start(); send_byte(8'hA2, a); send_byte(8'h23, a);
    i2c_start(); send_byte(8'hA1, a);
    check(a, "R1 repeated start read ack", a, 1);
    i2c_start(); send_byte(8'hA1, a); i2c_stop();
    check(!a, "R10 read refused after start abort", a, 0);

    // R10 abort by stop
    rand_read(11'h125, ok, d);
    check(d == 8'h0F, "R10 random read restores", d, 8'h0F);
    i2c_start(); send_byte(8'hA1, a); i2c_stop();
    check(a, "R10 read acked before stop abort", a, 1);
    i2c_start(); send_byte(8'hA1, a); i2c_stop();
    check(!a, "R10 read refused after stop abort", a, 0);
    rand_read(11'h7FF, ok, d);
    check(ok && d == 8'h81, "R10 valid again", d, 8'h81);
    cur_read(ok, d);
    check(ok && d == 8'h7E, "R8 wrap 7FF to 000", d, 8'h7E);

    // R12 R13 reset during ACK
    i2c_start();
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'(8'hA0 >> i); tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1;
    tick(2);
    check(sda_low == 1'b1, "R4 slave ack driven", sda_low, 1);
    rst_n = 1'b0;
    #1;
    check(sda_low == 1'b0, "R12 reset releases at once", sda_low, 0);
    tick(3); scl = 1'b1; m_sda = 1'b1; tick(2);
    rst_n = 1'b1;
    tick(Q);
    cur_read(ok, d);
    check(!ok, "R13 current read refused after second reset", ok, 0);

    summary();
    $finish;
  end
endmodule